// File: doc/BRIEF.md
# Standby Rail Power-Up Sequencer

This block takes a platform from fully unpowered to standby and back. On a power-up request it switches on the 5 V standby rail, then the 3.3 V rail, then the 1.8 V rail, each only after the previous rail has been reported good. The 3.3 V rail has no power-good pin of its own, so an external analog monitor supplies a "rail good" flag. Two further rails, an intermediate core rail and a 1.05 V rail, come up by hardware chaining behind 1.8 V. Their good state is seen on a single 1.05 V power-good input. After all of this, the block waits a settling delay before it releases the active-low reset of the platform controller hub.

Power-down runs in strict reverse order. The hub reset goes low first and is held for a minimum time. Then 1.8 V, 3.3 V and 5 V switch off on successive cycles. Any stalled power-good wait ends in a timeout. The timeout drives a forced shutdown: a one-cycle kill pulse goes to the active-rail sequencer, the standby rails are taken down, and a sticky fault code is shown. All delays and the timeout derive from the clock-frequency parameter. Every power-good input passes through a two-flop synchronizer.

Top module: `stby_seq_top`

## Requirements
- R1: During and just after reset, all three rail enables are 0, `hub_rst_n` is 0, `active_kill` is 0 and `seq_status` is 0.
- R2: Each power-good input is synchronized by two flops, so an input change acts on the outputs at the third rising clock edge after it. `en_5v` rises on the first edge after a `pwr_req` rising edge. `en_3v3` rises only after `pg_5v` is seen. `en_1v8` rises only after `ok_3v3_mon` is seen. While on, `en_3v3` implies `en_5v`, and `en_1v8` implies `en_3v3`.
- R3: After `en_1v8` rises, the sequencer advances only when `pg_1v8` and `pg_1v05` are both high. Either one alone leaves the hub in reset.
- R4: `hub_rst_n` rises exactly ceil(CLK_HZ/100) cycles after the sequencer sees both 1.8 V and 1.05 V good. That is at least 10 ms.
- R5: A `pwr_req` rising edge while `pwr_allow` is 0 enables no rail, gives a one-cycle `active_kill` pulse on the next cycle, and leaves the status at off.
- R6: If a power-good wait (5 V, 3.3 V monitor, 1.8 V plus 1.05 V) lasts CLK_HZ cycles without success, the block pulses `active_kill` for one cycle and powers down. It then reports fault.
- R7: Power-down drives `hub_rst_n` low first and holds it for ceil(CLK_HZ/2 500 000) cycles, at least one cycle, which is at least 400 ns. It then clears `en_1v8`, clears `en_3v3` one cycle later, and clears `en_5v` one cycle after that. A rail that was never enabled stays off.
- R8: In standby, loss of any one of the four synchronized good inputs starts a power-down that ends in off, not fault.
- R9: The fault code persists, whatever the request level, until the next `pwr_req` rising edge.
- R10: Dropping `pwr_req` before standby is reached aborts the power-up through the normal power-down order. No fault is reported.
- R11: `seq_status` encodes 0 off, 1 powering up, 2 standby, 3 powering down, 4 fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_req | input | 1 | Level request to be in standby; a rising edge starts power-up |
| pwr_allow | input | 1 | Power-up permission, sampled on the request edge |
| pg_5v | input | 1 | 5 V power-good (asynchronous) |
| ok_3v3_mon | input | 1 | Analog monitor flag: 3.3 V above threshold (asynchronous) |
| pg_1v8 | input | 1 | 1.8 V power-good (asynchronous) |
| pg_1v05 | input | 1 | 1.05 V power-good, end of the hardware chain (asynchronous) |
| en_5v | output | 1 | 5 V rail enable |
| en_3v3 | output | 1 | 3.3 V rail enable |
| en_1v8 | output | 1 | 1.8 V rail enable |
| hub_rst_n | output | 1 | Active-low platform controller hub reset |
| active_kill | output | 1 | One-cycle forced-shutdown request to the active-rail sequencer |
| seq_status | output | 3 | Sequencer status code |

## Verification
The hardest case to reach is a timeout in each of the three wait stages. Each timeout has to arrive at the exact cycle, with only the rails of the earlier stages switched on. The stimulus sweeps the stall point over all three stages. It releases power-good inputs up to that stage and then withholds the next one. With the clock-frequency parameter set to 1000, the full timeout is 1000 cycles. The bench counts those cycles from the edge on which the stalled rail was enabled. A second sweep drops each of the four good inputs in turn while in standby. This shows that each one alone triggers a clean, fault-free shutdown.

// File: rtl/stby_seq_pkg.sv
package stby_seq_pkg;

    typedef enum logic [3:0] {
        S_OFF,
        S_UP5,
        S_UP33,
        S_UP18,
        S_SETTLE,
        S_STBY,
        S_DN_HOLD,
        S_DN18,
        S_DN33
    } seq_st_e;

    typedef enum logic [2:0] {
        STAT_OFF   = 3'd0,
        STAT_UP    = 3'd1,
        STAT_STBY  = 3'd2,
        STAT_DOWN  = 3'd3,
        STAT_FAULT = 3'd4
    } stat_e;

    typedef struct packed {
        logic p5;
        logic v33;
        logic p18;
        logic p105;
    } pg_t;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic stat_e stat_of(input seq_st_e s, input logic fault);
        case (s)
            S_OFF:                      return fault ? STAT_FAULT : STAT_OFF;
            S_UP5, S_UP33, S_UP18,
            S_SETTLE:                   return STAT_UP;
            S_STBY:                     return STAT_STBY;
            default:                    return STAT_DOWN;
        endcase
    endfunction

endpackage

// File: rtl/stby_sync.sv
module stby_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= '0;
                else     stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/stby_timer.sv
module stby_timer #(
    parameter int CNT_W = 8,
    parameter int LIMIT = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

    always_ff @(posedge clk) begin
        if (rst || restart)  cnt <= '0;
        else if (cnt != LIM) cnt <= cnt + 1'b1;
    end

    assert_cnt_saturates_R6: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIM);
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
    import stby_seq_pkg::*;
#(
    parameter int TMO_CYC  = 1000,
    parameter int DLY_CYC  = 10,
    parameter int HOLD_CYC = 1,
    parameter int CNT_W    = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             allow,
    input  pg_t              pg,
    input  logic [CNT_W-1:0] cnt,
    output logic             restart,
    output logic             en5,
    output logic             en33,
    output logic             en18,
    output logic             hub_n,
    output logic             kill,
    output logic [2:0]       status
);
    localparam logic [CNT_W-1:0] TMO_LAST  = CNT_W'(TMO_CYC - 1);
    localparam logic [CNT_W-1:0] DLY_LAST  = CNT_W'(DLY_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);

    seq_st_e st, nxt;
    logic    req_q, fault_q;
    logic    req_rise, to_fault, deny, tmo_hit, all_good;

    assign req_rise = req & ~req_q;
    assign tmo_hit  = (cnt == TMO_LAST);
    assign all_good = pg.p5 & pg.v33 & pg.p18 & pg.p105;

    always_comb begin
        nxt      = st;
        to_fault = 1'b0;
        deny     = 1'b0;
        case (st)
            S_OFF: begin
                if (req_rise) begin
                    if (allow) nxt  = S_UP5;
                    else       deny = 1'b1;
                end
            end
            S_UP5: begin
                if (!req)          nxt = S_DN_HOLD;
                else if (pg.p5)    nxt = S_UP33;
                else if (tmo_hit) begin
                    nxt      = S_DN_HOLD;
                    to_fault = 1'b1;
                end
            end
            S_UP33: begin
                if (!req)          nxt = S_DN_HOLD;
                else if (pg.v33)   nxt = S_UP18;
                else if (tmo_hit) begin
                    nxt      = S_DN_HOLD;
                    to_fault = 1'b1;
                end
            end
            S_UP18: begin
                if (!req)                   nxt = S_DN_HOLD;
                else if (pg.p18 && pg.p105) nxt = S_SETTLE;
                else if (tmo_hit) begin
                    nxt      = S_DN_HOLD;
                    to_fault = 1'b1;
                end
            end
            S_SETTLE: begin
                if (!req)                 nxt = S_DN_HOLD;
                else if (cnt == DLY_LAST) nxt = S_STBY;
            end
            S_STBY: begin
                if (!req || !all_good) nxt = S_DN_HOLD;
            end
            S_DN_HOLD: begin
                if (cnt == HOLD_LAST) nxt = S_DN18;
            end
            S_DN18:  nxt = S_DN33;
            S_DN33:  nxt = S_OFF;
            default: nxt = S_OFF;
        endcase
    end

    assign restart = (nxt != st);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_OFF;
            req_q   <= 1'b0;
            fault_q <= 1'b0;
            kill    <= 1'b0;
            en5     <= 1'b0;
            en33    <= 1'b0;
            en18    <= 1'b0;
            hub_n   <= 1'b0;
        end else begin
            st    <= nxt;
            req_q <= req;
            kill  <= to_fault | deny;
            if (st == S_OFF && req_rise) fault_q <= 1'b0;
            else if (to_fault)           fault_q <= 1'b1;
            if (nxt == S_UP5)  en5  <= 1'b1;
            else if (nxt == S_OFF) en5 <= 1'b0;
            if (nxt == S_UP33) en33 <= 1'b1;
            else if (nxt == S_DN33) en33 <= 1'b0;
            if (nxt == S_UP18) en18 <= 1'b1;
            else if (nxt == S_DN18) en18 <= 1'b0;
            if (nxt == S_STBY) hub_n <= 1'b1;
            else if (nxt == S_DN_HOLD) hub_n <= 1'b0;
        end
    end

    assign status = stat_of(st, fault_q);

    assert_3v3_needs_5v_R2: assert property (@(posedge clk) disable iff (rst)
        en33 |-> en5);
    assert_1v8_needs_3v3_R2: assert property (@(posedge clk) disable iff (rst)
        en18 |-> en33);
    assert_hub_needs_rails_R4: assert property (@(posedge clk) disable iff (rst)
        hub_n |-> (en18 && en5));
    assert_reset_before_1v8_off_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(en18) |-> (!hub_n && $past(!hub_n)));
    assert_kill_single_R6: assert property (@(posedge clk) disable iff (rst)
        kill |=> !kill);
    assert_fault_all_off_R9: assert property (@(posedge clk) disable iff (rst)
        (status == 3'(STAT_FAULT)) |-> (!en5 && !en33 && !en18 && !hub_n));
endmodule

// File: rtl/stby_seq_top.sv
module stby_seq_top
    import stby_seq_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_req,
    input  logic       pwr_allow,
    input  logic       pg_5v,
    input  logic       ok_3v3_mon,
    input  logic       pg_1v8,
    input  logic       pg_1v05,
    output logic       en_5v,
    output logic       en_3v3,
    output logic       en_1v8,
    output logic       hub_rst_n,
    output logic       active_kill,
    output logic [2:0] seq_status
);
    localparam int TMO_CYC  = at_least_one(CLK_HZ);
    localparam int DLY_CYC  = at_least_one(ceil_div(CLK_HZ, 100));
    localparam int HOLD_CYC = at_least_one(ceil_div(CLK_HZ, 2_500_000));
    localparam int TOP_CYC  = max3(TMO_CYC, DLY_CYC, HOLD_CYC);
    localparam int CNT_W    = $clog2(TOP_CYC + 1);

    pg_t              pg_raw, pg_s;
    logic             restart;
    logic [CNT_W-1:0] cnt;

    assign pg_raw = '{p5: pg_5v, v33: ok_3v3_mon, p18: pg_1v8, p105: pg_1v05};

    stby_sync #(.W($bits(pg_t)), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pg_raw),
        .q   (pg_s)
    );

    stby_timer #(.CNT_W(CNT_W), .LIMIT(TOP_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .cnt     (cnt)
    );

    stby_fsm #(
        .TMO_CYC  (TMO_CYC),
        .DLY_CYC  (DLY_CYC),
        .HOLD_CYC (HOLD_CYC),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .req     (pwr_req),
        .allow   (pwr_allow),
        .pg      (pg_s),
        .cnt     (cnt),
        .restart (restart),
        .en5     (en_5v),
        .en33    (en_3v3),
        .en18    (en_1v8),
        .hub_n   (hub_rst_n),
        .kill    (active_kill),
        .status  (seq_status)
    );
endmodule

// File: tb/stby_seq_top_tb.sv
module stby_seq_top_tb;
    localparam int HZ   = 1000;
    localparam int TMO  = HZ;
    localparam int DLY  = (HZ + 99) / 100;
    localparam int HOLD = ((HZ + 2_499_999) / 2_500_000 < 1) ? 1 : (HZ + 2_499_999) / 2_500_000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_req = 0, pwr_allow = 0;
    logic pg_5v = 0, ok_3v3_mon = 0, pg_1v8 = 0, pg_1v05 = 0;
    logic en_5v, en_3v3, en_1v8, hub_rst_n, active_kill;
    logic [2:0] seq_status;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    stby_seq_top #(.CLK_HZ(HZ)) u_dut (
        .clk(clk), .rst(rst), .pwr_req(pwr_req), .pwr_allow(pwr_allow),
        .pg_5v(pg_5v), .ok_3v3_mon(ok_3v3_mon), .pg_1v8(pg_1v8), .pg_1v05(pg_1v05),
        .en_5v(en_5v), .en_3v3(en_3v3), .en_1v8(en_1v8), .hub_rst_n(hub_rst_n),
        .active_kill(active_kill), .seq_status(seq_status)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: actual hung run expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        pwr_req = 0; pg_5v = 0; ok_3v3_mon = 0; pg_1v8 = 0; pg_1v05 = 0;
        step(8);
    endtask

    // reach standby with exact edge counting (two sync flops + state edge)
    task automatic full_up();
        pwr_allow = 1; pwr_req = 1;
        step(1);
        check("R2 en_5v after request", en_5v, 1);
        check("R2 en_3v3 still off", en_3v3, 0);
        check("R11 status powering up", seq_status, 1);
        pg_5v = 1;
        step(2);
        check("R2 en_3v3 before sync", en_3v3, 0);
        step(1);
        check("R2 en_3v3 after pg_5v", en_3v3, 1);
        ok_3v3_mon = 1;
        step(2);
        check("R2 en_1v8 before sync", en_1v8, 0);
        step(1);
        check("R2 en_1v8 after monitor", en_1v8, 1);
        pg_1v8 = 1;
        step(20);
        check("R3 hub held with 1v8 only", hub_rst_n, 0);
        pg_1v05 = 1;
        step(2 + DLY);
        check("R4 hub still in reset", hub_rst_n, 0);
        step(1);
        check("R4 hub released", hub_rst_n, 1);
        check("R11 status standby", seq_status, 2);
    endtask

    // dn_obs: number of steps until DN_HOLD is observed
    task automatic power_down(input string tag, input int dn_obs, input int fin);
        step(dn_obs);
        check({tag, " hub asserted first"}, hub_rst_n, 0);
        check({tag, " status down"}, seq_status, 3);
        step(HOLD);
        check({tag, " 1v8 off"}, en_1v8, 0);
        check({tag, " 5v on at 1v8 off"}, en_5v, 1);
        step(1);
        check({tag, " 3v3 off"}, en_3v3, 0);
        check({tag, " 5v still on"}, en_5v, 1);
        step(1);
        check({tag, " 5v off"}, en_5v, 0);
        check({tag, " final status"}, seq_status, fin);
    endtask

    initial begin
        step(3);
        check("R1 en_5v in reset", en_5v, 0);
        check("R1 hub in reset", hub_rst_n, 0);
        @(negedge clk) rst = 1'b0;
        step(2);
        check("R1 enables off", {en_5v, en_3v3, en_1v8}, 0);
        check("R1 kill off", active_kill, 0);
        check("R1 status off", seq_status, 0);

        // normal up and down
        full_up();
        pwr_req = 0;
        power_down("R7", 1, 0);
        clear_all();

        // standby loss of each good input
        for (int k = 0; k < 4; k++) begin
            full_up();
            case (k)
                0: pg_5v = 0;
                1: ok_3v3_mon = 0;
                2: pg_1v8 = 0;
                default: pg_1v05 = 0;
            endcase
            step(2);
            check("R8 standby before sync", seq_status, 2);
            power_down("R8", 1, 0);
            check("R8 no kill", active_kill, 0);
            clear_all();
        end

        // permission denied
        pwr_allow = 0; pwr_req = 1;
        step(1);
        check("R5 kill pulse", active_kill, 1);
        check("R5 no 5v", en_5v, 0);
        check("R5 status off", seq_status, 0);
        step(1);
        check("R5 kill single", active_kill, 0);
        step(5);
        check("R5 still no rails", {en_5v, en_3v3, en_1v8}, 0);
        pwr_req = 0; pwr_allow = 1;
        step(2);

        // timeout in each wait stage
        for (int s = 0; s < 3; s++) begin
            pwr_allow = 1; pwr_req = 1;
            step(1);
            if (s >= 1) begin pg_5v = 1; step(3); end
            if (s >= 2) begin ok_3v3_mon = 1; step(3); end
            check("R6 stalled rail on", {en_5v, en_3v3, en_1v8}, (1 << (3 - s - 1)) * 0 + ((s == 0) ? 4 : (s == 1) ? 6 : 7));
            step(TMO - 1);
            check("R6 still waiting", seq_status, 1);
            check("R6 no early kill", active_kill, 0);
            step(1);
            check("R6 status down at timeout", seq_status, 3);
            check("R6 kill at timeout", active_kill, 1);
            check("R6 rails kept at timeout", en_5v + en_3v3 + en_1v8, s + 1);
            step(1);
            check("R6 kill single", active_kill, 0);
            step(HOLD - 1);
            check("R7 1v8 off after hold", en_1v8, 0);
            step(2);
            check("R6 5v off", en_5v, 0);
            check("R6 fault code", seq_status, 4);
            pg_5v = 0; ok_3v3_mon = 0;
            step(50);
            check("R9 fault held with request high", seq_status, 4);
            pwr_req = 0;
            step(5);
            check("R9 fault held with request low", seq_status, 4);
            pwr_req = 1;
            step(1);
            check("R9 fault cleared by request", seq_status, 1);
            pwr_req = 0;
            step(1);
            check("R10 abort status down", seq_status, 3);
            step(HOLD + 2);
            check("R10 abort ends off", seq_status, 0);
            check("R10 abort rails off", {en_5v, en_3v3, en_1v8}, 0);
            clear_all();
        end

        // abort while waiting on 1.8 V
        pwr_allow = 1; pwr_req = 1;
        step(1);
        pg_5v = 1; step(3);
        ok_3v3_mon = 1; step(3);
        check("R10 1v8 on before abort", en_1v8, 1);
        pwr_req = 0;
        power_down("R10", 1, 0);
        clear_all();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule